// File: doc/BRIEF.md
# Lockable Memory-Controller Register File

This block is the software-visible register bank of a DRAM controller. A host reaches it over a simple word-addressed bus. Each request is a one-cycle read or write strobe with a word index and write data. The block answers one cycle later with registered read data and a ready pulse. Every register is 32 bits wide, and the word index is the byte offset shifted right by two.

Writes pass through a two-level lock held in a protection word at index 0. In the soft-locked state, only the protection word accepts writes, so software can unlock the bank again. In the hard-locked state, the protection word is frozen as well, and only a system reset clears it. A short list of test, interrupt and tuning registers bypasses the lock entirely.

The configuration word at index 1 always shows a set of fixed hardware fields, whatever software writes to it. These are a version number, an aperture code and a RAM-size code. The RAM-size code is the position of the configured size in the variant's list of allowed sizes. At reset, the bank also loads healthy PHY status and eye-window values into its PHY area. A write that the lock rejects raises a one-cycle `blocked_write` pulse and changes nothing.

Top module: `memctl_regbank`

## Requirements
- R1: Reads and writes are word-addressed with `NUM_REGS` = 320 words. A request on a clock edge produces `rsp_ready` high for exactly the following cycle. On a read, `rsp_rdata` carries the stored word in that same following cycle. After reset, `rsp_ready` and `blocked_write` are low and ordinary registers read 0.
- R2: Writes to word indices 20, 27, 29, 30, 31, 34, 35 and 45 (byte offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C, 0xB4) always store the data, in every lock state.
- R3: While soft-locked, a write to any register other than index 0 or the bypass list is ignored. A write to index 0 is still accepted, so software can unlock the bank.
- R4: While hard-locked, every write outside the bypass list is ignored, including writes to index 0. Only reset returns the bank to the unlocked state.
- R5: Writing 0xA5A50001 to index 0 unlocks the bank and stores 0xA5A50001. Writing 0xDEAD10CC hard-locks the bank and stores 0xDEAD10CC. Any other value soft-locks the bank and stores 0x00000001. Index 0 resets to 0xA5A50001, which means unlocked.
- R6: In the config word (index 1), bits [31:28] hold the version (3), bits [3:2] hold the aperture code (1) and bits [1:0] hold the RAM-size code. These fields are always forced from hardware. All other bits take the written data.
- R7: The RAM-size code is the index of `RAM_MB` in the list `MIN_MB << i` for i = 0..3. With the defaults (256, 512, 1024 and 2048 MB, configured size 1024 MB) the code is 2, so the config word resets to 0x30000006.
- R8: At reset, index 0x100 (PHY status) holds 0x00000002, meaning PHY ok and both calibrations ok. Indices 0x11A and 0x11F hold 0x000000FF. Index 0x114 holds 0x0FFFFFFF.
- R9: A read at an index of 320 or above returns 0. A write there is dropped without a `blocked_write` pulse.
- R10: A write rejected by the lock raises `blocked_write` for exactly the following cycle and leaves all registers unchanged.
- R11: Index 24 always reads 0x00000010, meaning PLL locked (bit 4 = 1) and PHY not busy (bit 0 = 0), whatever is written to it. Index 28 always reads with bit 12 (test finished) set and bit 13 (test failed) clear. Its other bits keep the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_addr | input | 10 | Word index |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| rsp_ready | output | 1 | Response valid, one cycle after a request |
| blocked_write | output | 1 | One-cycle pulse for a lock-rejected write |

## Verification
The bench moves the bank through the states unlocked, soft-locked, unlocked, hard-locked and then reset, and tries the same kinds of write in each state.

- A design that forgot the bypass list would drop the writes to index 20 and index 45 under lock.
- A design that let index 0 through in the hard-locked state would read back the unlock key.
- A design that treated soft lock as hard lock could never unlock.
- Writing all ones to the config word exposes any leak into the forced fields.
- Writes to the status and ECC words expose any missing read overlay.
- Index 320 catches address aliasing onto low registers and a missing out-of-range zero.

// File: rtl/memctl_regbank_pkg.sv
package memctl_regbank_pkg;

  typedef enum logic [1:0] {
    LK_OPEN = 2'd0,
    LK_SOFT = 2'd1,
    LK_HARD = 2'd2
  } lock_e;

  // Position of ram_mb within the doubling list min_mb, 2*min_mb, ...
  function automatic int ram_size_code(int ram_mb, int min_mb, int count);
    int code;
    code = 0;
    for (int i = 0; i < count; i++) begin
      if ((min_mb << i) == ram_mb) code = i;
    end
    return code;
  endfunction

  // Writable bits come from software, read-only bits come from hardware.
  function automatic logic [31:0] cfg_merge(logic [31:0] wdata, logic [31:0] fixed,
                                            logic [31:0] ro_mask);
    return (wdata & ~ro_mask) | fixed;
  endfunction

  // Word indices that stay writable in every lock state.
  function automatic logic is_bypass(int idx);
    case (idx)
      20, 27, 29, 30, 31, 34, 35, 45: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/memctl_wr_gate.sv
module memctl_wr_gate
  import memctl_regbank_pkg::*;
#(
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          in_range,
  input  logic [IW-1:0] idx,
  input  lock_e         lock_st,
  output logic          accept,
  output logic          reject,
  output logic          bypass_hit
);

  logic is_prot;

  assign bypass_hit = is_bypass(int'(idx));
  assign is_prot    = (idx == '0);

  always_comb begin
    accept = 1'b0;
    reject = 1'b0;
    if (wr_en && in_range) begin
      if (bypass_hit) begin
        accept = 1'b1;
      end else begin
        unique case (lock_st)
          LK_OPEN: accept = 1'b1;
          LK_SOFT: begin
            accept = is_prot;
            reject = !is_prot;
          end
          default: reject = 1'b1;
        endcase
      end
    end
  end

  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(accept && reject));
  // R9
  oor_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |-> (!accept && !reject));

endmodule

// File: rtl/memctl_reg_store.sv
module memctl_reg_store
  import memctl_regbank_pkg::*;
#(
  parameter int          NUM_REGS   = 320,
  parameter int          IW         = 9,
  parameter int          PHY_BASE   = 256,
  parameter logic [31:0] UNLOCK_KEY = 32'hA5A5_0001,
  parameter logic [31:0] HARD_KEY   = 32'hDEAD_10CC,
  parameter logic [31:0] SOFT_CODE  = 32'h0000_0001,
  parameter logic [31:0] CFG_FIXED  = 32'h3000_0006,
  parameter logic [31:0] CFG_RO     = 32'hF000_000F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] ridx,
  output logic [31:0]   rword,
  output logic [31:0]   prot_q
);

  localparam int CFG_IDX = 1;

  logic [31:0] mem [NUM_REGS];
  logic [31:0] next_word;

  function automatic logic [31:0] reset_word(int i);
    if (i == 0)             return UNLOCK_KEY;
    if (i == CFG_IDX)       return CFG_FIXED;
    if (i == PHY_BASE)      return 32'h0000_0002;
    if (i == PHY_BASE + 26) return 32'h0000_00FF;
    if (i == PHY_BASE + 31) return 32'h0000_00FF;
    if (i == PHY_BASE + 20) return 32'h0FFF_FFFF;
    return 32'h0;
  endfunction

  always_comb begin
    if (widx == '0) begin
      if (wdata == UNLOCK_KEY)    next_word = UNLOCK_KEY;
      else if (wdata == HARD_KEY) next_word = HARD_KEY;
      else                        next_word = SOFT_CODE;
    end else if (int'(widx) == CFG_IDX) begin
      next_word = cfg_merge(wdata, CFG_FIXED, CFG_RO);
    end else begin
      next_word = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= reset_word(i);
    end else if (we) begin
      mem[widx] <= next_word;
    end
  end

  assign rword  = mem[ridx];
  assign prot_q = mem[0];

  // R6
  cfg_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem[CFG_IDX] & CFG_RO) == CFG_FIXED);
  // R2
  bypass_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && is_bypass(int'(widx))) |=> (mem[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/memctl_regbank.sv
module memctl_regbank
  import memctl_regbank_pkg::*;
#(
  parameter int          NUM_REGS   = 320,
  parameter int          AW         = 10,
  parameter int          PHY_BASE   = 256,
  parameter int          RAM_MB     = 1024,
  parameter int          MIN_MB     = 256,
  parameter int          SIZE_COUNT = 4,
  parameter int          HW_VERSION = 3,
  parameter int          APERTURE   = 1,
  parameter logic [31:0] UNLOCK_KEY = 32'hA5A5_0001,
  parameter logic [31:0] HARD_KEY   = 32'hDEAD_10CC,
  parameter logic [31:0] SOFT_CODE  = 32'h0000_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_ready,
  output logic          blocked_write
);

  localparam int          IW        = $clog2(NUM_REGS);
  localparam int          SIZE_CODE = ram_size_code(RAM_MB, MIN_MB, SIZE_COUNT);
  localparam logic [31:0] CFG_RO    = 32'hF000_000F;
  localparam logic [31:0] CFG_FIXED = (32'(HW_VERSION) << 28) | (32'(APERTURE) << 2)
                                      | 32'(SIZE_CODE);
  localparam int          STAT_IDX  = 24;
  localparam int          ECC_IDX   = 28;
  localparam logic [31:0] STAT_WORD = 32'h0000_0010;
  localparam logic [31:0] ECC_DONE  = 32'h0000_1000;
  localparam logic [31:0] ECC_FAIL  = 32'h0000_2000;

  logic          in_range;
  logic [IW-1:0] idx;
  logic [31:0]   prot_q;
  logic [31:0]   rword;
  lock_e         lock_st;
  logic          accept;
  logic          reject;
  logic          bypass_hit;
  logic [31:0]   rd_view;

  assign in_range = (req_addr < AW'(NUM_REGS));
  assign idx      = req_addr[IW-1:0];

  always_comb begin
    if (prot_q == HARD_KEY)        lock_st = LK_HARD;
    else if (prot_q == UNLOCK_KEY) lock_st = LK_OPEN;
    else                           lock_st = LK_SOFT;
  end

  memctl_wr_gate #(.IW(IW)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (req_wr),
    .in_range   (in_range),
    .idx        (idx),
    .lock_st    (lock_st),
    .accept     (accept),
    .reject     (reject),
    .bypass_hit (bypass_hit)
  );

  memctl_reg_store #(
    .NUM_REGS   (NUM_REGS),
    .IW         (IW),
    .PHY_BASE   (PHY_BASE),
    .UNLOCK_KEY (UNLOCK_KEY),
    .HARD_KEY   (HARD_KEY),
    .SOFT_CODE  (SOFT_CODE),
    .CFG_FIXED  (CFG_FIXED),
    .CFG_RO     (CFG_RO)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (accept),
    .widx   (idx),
    .wdata  (req_wdata),
    .ridx   (idx),
    .rword  (rword),
    .prot_q (prot_q)
  );

  // Read view: out-of-range zero, status constant, ECC status bits forced.
  always_comb begin
    if (!in_range)                    rd_view = 32'h0;
    else if (int'(idx) == STAT_IDX)   rd_view = STAT_WORD;
    else if (int'(idx) == ECC_IDX)    rd_view = (rword & ~ECC_FAIL) | ECC_DONE;
    else                              rd_view = rword;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_rdata     <= 32'h0;
      rsp_ready     <= 1'b0;
      blocked_write <= 1'b0;
    end else begin
      rsp_rdata     <= req_rd ? rd_view : 32'h0;
      rsp_ready     <= req_rd || req_wr;
      blocked_write <= reject;
    end
  end

  // R1
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd || req_wr) |=> rsp_ready);
  // R10
  blocked_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (blocked_write && $stable(prot_q)));
  // R4
  hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_st == LK_HARD) |=> (lock_st == LK_HARD));
  // R9
  oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !in_range) |=> (rsp_rdata == 32'h0));
  // R3
  soft_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_st == LK_SOFT && req_wr && in_range && !bypass_hit && idx != '0) |=> blocked_write);

endmodule

// File: tb/memctl_regbank_tb.sv
module memctl_regbank_tb;

  localparam logic [31:0] K_OPEN = 32'hA5A5_0001;
  localparam logic [31:0] K_HARD = 32'hDEAD_10CC;
  localparam logic [31:0] K_SOFT = 32'h0000_0001;

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        blk;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 10'd1,   32'h0,         32'h3000_0006, 1'b0, 4'd7},  // R7 reset config
    '{1'b1, 10'd1,   32'hFFFF_FFFF, 32'h0,         1'b0, 4'd6},
    '{1'b0, 10'd1,   32'h0,         32'h3FFF_FFF6, 1'b0, 4'd6},  // R6 forced fields
    '{1'b1, 10'd16,  32'h1111_2222, 32'h0,         1'b0, 4'd1},
    '{1'b0, 10'd16,  32'h0,         32'h1111_2222, 1'b0, 4'd1},  // R1
    '{1'b1, 10'd0,   32'h0000_0077, 32'h0,         1'b0, 4'd5},  // soft lock
    '{1'b0, 10'd0,   32'h0,         K_SOFT,        1'b0, 4'd5},  // R5
    '{1'b1, 10'd16,  32'h0,         32'h0,         1'b1, 4'd3},  // R3 rejected
    '{1'b0, 10'd16,  32'h0,         32'h1111_2222, 1'b0, 4'd3},
    '{1'b1, 10'd20,  32'hABCD_0001, 32'h0,         1'b0, 4'd2},  // R2 under soft lock
    '{1'b0, 10'd20,  32'h0,         32'hABCD_0001, 1'b0, 4'd2},
    '{1'b1, 10'd0,   K_OPEN,        32'h0,         1'b0, 4'd3},  // R3 unlock
    '{1'b0, 10'd0,   32'h0,         K_OPEN,        1'b0, 4'd5},
    '{1'b1, 10'd16,  32'h5,         32'h0,         1'b0, 4'd3},
    '{1'b0, 10'd16,  32'h0,         32'h5,         1'b0, 4'd3},
    '{1'b0, 10'd24,  32'h0,         32'h10,        1'b0, 4'd11}, // R11 status
    '{1'b1, 10'd24,  32'hFFFF_FFFF, 32'h0,         1'b0, 4'd11},
    '{1'b0, 10'd24,  32'h0,         32'h10,        1'b0, 4'd11},
    '{1'b1, 10'd28,  32'hFFFF_FFFF, 32'h0,         1'b0, 4'd11},
    '{1'b0, 10'd28,  32'h0,         32'hFFFF_DFFF, 1'b0, 4'd11}, // R11 ECC bits
    '{1'b1, 10'd28,  32'h0,         32'h0,         1'b0, 4'd11},
    '{1'b0, 10'd28,  32'h0,         32'h0000_1000, 1'b0, 4'd11},
    '{1'b0, 10'd320, 32'h0,         32'h0,         1'b0, 4'd9},  // R9
    '{1'b1, 10'd320, 32'hFFFF_FFFF, 32'h0,         1'b0, 4'd9},
    '{1'b0, 10'd1023,32'h0,         32'h0,         1'b0, 4'd9},
    '{1'b0, 10'd256, 32'h0,         32'h2,         1'b0, 4'd8},  // R8 PHY status
    '{1'b0, 10'd282, 32'h0,         32'hFF,        1'b0, 4'd8},
    '{1'b0, 10'd287, 32'h0,         32'hFF,        1'b0, 4'd8},
    '{1'b0, 10'd276, 32'h0,         32'h0FFF_FFFF, 1'b0, 4'd8},
    '{1'b1, 10'd0,   K_HARD,        32'h0,         1'b0, 4'd5},  // hard lock
    '{1'b0, 10'd0,   32'h0,         K_HARD,        1'b0, 4'd5},
    '{1'b1, 10'd0,   K_OPEN,        32'h0,         1'b1, 4'd4},  // R4 unlock refused
    '{1'b0, 10'd0,   32'h0,         K_HARD,        1'b0, 4'd4},
    '{1'b1, 10'd1,   32'h0,         32'h0,         1'b1, 4'd4},
    '{1'b0, 10'd1,   32'h0,         32'h3FFF_FFF6, 1'b0, 4'd4},
    '{1'b1, 10'd45,  32'h99,        32'h0,         1'b0, 4'd2},  // R2 under hard lock
    '{1'b0, 10'd45,  32'h0,         32'h99,        1'b0, 4'd2},
    '{1'b1, 10'd0,   32'h0000_0077, 32'h0,         1'b1, 4'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_rd = 1'b0;
  logic        req_wr = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_ready;
  logic        blocked_write;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  memctl_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_ready(rsp_ready), .blocked_write(blocked_write)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [9:0] a, logic [31:0] d, logic exp_blk, string tag);
    @(negedge clk);
    req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
    check({tag, " blocked_write"}, 32'(blocked_write), 32'(exp_blk));
    check({tag, " ready"}, 32'(rsp_ready), 32'h1);
    @(negedge clk);
    // R10 pulse lasts one cycle only
    check("R10 pulse width", 32'(blocked_write), 32'h0);
  endtask

  task automatic do_read(logic [9:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    req_rd = 1'b1; req_addr = a;
    @(negedge clk);
    req_rd = 1'b0;
    check({tag, " rdata"}, rsp_rdata, exp);
    check({tag, " ready"}, 32'(rsp_ready), 32'h1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 reset ready", 32'(rsp_ready), 32'h0);
    check("R1 reset blocked", 32'(blocked_write), 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      if (VEC[i].wr) do_write(VEC[i].addr, VEC[i].data, VEC[i].blk, tag);
      else           do_read(VEC[i].addr, VEC[i].exp, tag);
    end

    // R2: whole bypass list writable while hard-locked
    begin
      int bl[8] = '{20, 27, 29, 30, 31, 34, 35, 45};
      foreach (bl[k]) do_write(10'(bl[k]), 32'hC0DE_0000 + 32'(k), 1'b0, "R2 bypass");
      foreach (bl[k]) do_read(10'(bl[k]), 32'hC0DE_0000 + 32'(k), "R2 bypass");
    end

    // R4: only reset clears the hard lock
    do_reset();
    @(negedge clk);
    check("R1 reset ready again", 32'(rsp_ready), 32'h0);
    do_read(10'd0, K_OPEN, "R4 reset unlocks");
    do_read(10'd16, 32'h0, "R1 reset clears reg");
    do_read(10'd20, 32'h0, "R1 reset clears bypass reg");
    do_read(10'd1, 32'h3000_0006, "R7 config after reset");
    do_write(10'd16, 32'h7777_0000, 1'b0, "R4 write after reset");
    do_read(10'd16, 32'h7777_0000, "R4 write after reset");

    // R3: soft lock on, still refused, then index 0 can hard-lock
    do_write(10'd0, 32'h1234_5678, 1'b0, "R3 soft lock");
    do_write(10'd1, 32'h0000_0100, 1'b1, "R3 config refused");
    do_read(10'd1, 32'h3000_0006, "R3 config unchanged");
    do_write(10'd0, K_HARD, 1'b0, "R3 soft to hard");
    do_read(10'd0, K_HARD, "R5 hard key stored");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule